// File: doc/BRIEF.md
# Inline Checksum and CRC Unit

This block sits beside a byte-wide copy datapath and observes every byte moved. It keeps two running values: a 16-bit ones'-complement sum of the kind used by TCP and UDP, and a 32-bit reflected CRC. Both values survive from one move to the next, so a packet assembled from several separate moves yields one checksum and one CRC.

Each move begins with a `start` pulse that carries a flag byte. The flags turn each function on, reseed its running value, or request that its result be added to the output stream. After `end_move`, the block can emit the four CRC bytes and then the two checksum bytes on consecutive cycles. When the checksum is on, the emitted CRC bytes are folded into the sum before the checksum goes out. Two further flags select between two CRC polynomials and reverse the bit order inside every CRC byte at the end of the move.

Top module: `inline_cksum_crc`

## Requirements
- R1: After reset, `out_valid` is 0, `csum_partial` is 0x0000 and `crc_partial` is 0xFFFFFFFF.
- R2: A `start` accepted with flag bit 4 (CRC reseed) loads `crc_partial` with 0xFFFFFFFF. A `start` accepted with flag bit 1 (sum reseed) loads `csum_partial` with 0 and sets the byte phase to even. If a reseed bit is clear, that running value is carried over from the previous move.
- R3: With flag bit 3 set, each accepted byte updates the CRC in reflected form, least significant bit first. Flag bit 7 clear selects polynomial 0xEDB88320 and flag bit 7 set selects 0x82F63B78. With flag bit 3 clear, accepted bytes leave `crc_partial` unchanged.
- R4: With flag bit 0 set, accepted bytes are added alternately as the high and low half of a 16-bit word, using end-around carry. The byte phase carries across moves. With flag bit 0 clear, accepted bytes leave `csum_partial` unchanged.
- R5: With flag bit 5 set, the block emits `~crc_partial` on `out_data`, least significant byte first, one byte per cycle. The first byte appears in the cycle after `end_move` is taken.
- R6: With flag bit 2 set, the block emits `~csum_partial`, high byte first, one byte per cycle. These bytes follow any appended CRC bytes directly, or start in the cycle after `end_move` if no CRC is appended.
- R7: When flag bits 5 and 0 are both set, each appended CRC byte is added to the running sum at the current byte phase before the checksum is emitted.
- R8: With flag bit 6 set, `crc_partial` has the bits reversed within each byte at the end of the move. Appended CRC bytes are taken from that reversed value.
- R9: A byte presented in the same cycle as `end_move` is included in both running values before anything is appended.
- R10: The block ignores `in_valid` bytes and `end_move` when no move is open. It ignores `start`, bytes and `end_move` while it is appending (`out_valid` high). Ignored inputs leave both running values and the output sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a move and latches `flags` |
| flags | input | 8 | Per-move control: 0 sum on, 1 sum reseed, 2 sum append, 3 CRC on, 4 CRC reseed, 5 CRC append, 6 CRC byte bit reversal, 7 polynomial select |
| in_valid | input | 1 | A copied byte is present on `in_data` |
| in_data | input | 8 | Copied byte |
| end_move | input | 1 | Closes the open move |
| out_valid | output | 1 | An appended byte is present on `out_data` |
| out_data | output | 8 | Appended CRC or checksum byte |
| csum_partial | output | 16 | Running ones'-complement sum |
| crc_partial | output | 32 | Running CRC register |

## Verification
Two kinds of event can land on the same clock edge. The first is the last data byte arriving together with `end_move`. The second is an appended CRC byte being emitted while it is also added into the sum that the checksum bytes then carry. The bench drives the first by asserting `in_valid` and `end_move` in one cycle with an odd byte count, which leaves the sum phase odd. It drives the second by setting both append flags with the sum on. A behavioural queue model predicts every emitted byte and both running values on every clock, and a wrong merge of these events shows up as a wrong checksum byte or a wrong final sum.

// File: rtl/ckcrc_pkg.sv
package ckcrc_pkg;

    localparam int BYTE_W = 8;
    localparam int SUM_W  = 16;
    localparam int CRC_W  = 32;
    localparam int CRC_BYTES = CRC_W / BYTE_W;
    localparam int SUM_BYTES = SUM_W / BYTE_W;
    localparam int IDX_W = $clog2(CRC_BYTES);

    localparam logic [CRC_W-1:0] POLY_STD  = 32'hEDB88320;
    localparam logic [CRC_W-1:0] POLY_CAST = 32'h82F63B78;
    localparam logic [CRC_W-1:0] CRC_SEED  = 32'hFFFFFFFF;
    localparam logic [SUM_W-1:0] SUM_SEED  = 16'h0000;

    // Last member sits at bit 0.
    typedef struct packed {
        logic def_sel;
        logic crc_swap;
        logic crc_app;
        logic crc_rst;
        logic crc_en;
        logic sum_app;
        logic sum_rst;
        logic sum_en;
    } move_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_ACRC = 2'd2,
        ST_ASUM = 2'd3
    } move_state_t;

    function automatic logic [CRC_W-1:0] crc_step8(
        input logic [CRC_W-1:0]  c,
        input logic [BYTE_W-1:0] b,
        input logic [CRC_W-1:0]  poly
    );
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] rev_in_bytes(input logic [CRC_W-1:0] w);
        logic [CRC_W-1:0] r;
        for (int k = 0; k < CRC_BYTES; k++) r[k*BYTE_W +: BYTE_W] = rev8(w[k*BYTE_W +: BYTE_W]);
        return r;
    endfunction

    function automatic logic [SUM_W-1:0] ones_add(
        input logic [SUM_W-1:0] a,
        input logic [SUM_W-1:0] b
    );
        logic [SUM_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SUM_W-1:0] + {{(SUM_W-1){1'b0}}, s[SUM_W]};
    endfunction

endpackage

// File: rtl/ckcrc_ctrl.sv
module ckcrc_ctrl
    import ckcrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  move_flags_t      flags_in,
    input  logic             in_valid,
    input  logic             end_move,
    output logic             crc_init,
    output logic             crc_step,
    output logic             crc_swap,
    output logic             crc_def,
    output logic             sum_clear,
    output logic             sum_step,
    output logic             app_crc,
    output logic             app_sum,
    output logic [IDX_W-1:0] app_idx
);
    move_state_t      st_q, st_d;
    move_flags_t      fl_q, fl_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    logic take_start, take_byte, take_end;

    assign take_start = start && (st_q == ST_IDLE || st_q == ST_MOVE);
    assign take_byte  = !start && (st_q == ST_MOVE) && in_valid;
    assign take_end   = !start && (st_q == ST_MOVE) && end_move;

    assign crc_init  = take_start && flags_in.crc_rst;
    assign sum_clear = take_start && flags_in.sum_rst;
    assign crc_step  = take_byte && fl_q.crc_en;
    assign crc_swap  = take_end && fl_q.crc_swap;
    assign crc_def   = fl_q.def_sel;
    assign app_crc   = (st_q == ST_ACRC);
    assign app_sum   = (st_q == ST_ASUM);
    assign app_idx   = idx_q;
    assign sum_step  = fl_q.sum_en && (take_byte || app_crc);

    always_comb begin
        st_d  = st_q;
        fl_d  = fl_q;
        idx_d = idx_q;
        if (take_start) begin
            st_d = ST_MOVE;
            fl_d = flags_in;
        end else begin
            unique case (st_q)
                ST_MOVE: if (take_end) begin
                    idx_d = '0;
                    if (fl_q.crc_app)      st_d = ST_ACRC;
                    else if (fl_q.sum_app) st_d = ST_ASUM;
                    else                   st_d = ST_IDLE;
                end
                ST_ACRC: begin
                    if (idx_q == IDX_W'(CRC_BYTES-1)) begin
                        idx_d = '0;
                        st_d  = fl_q.sum_app ? ST_ASUM : ST_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_ASUM: begin
                    if (idx_q == IDX_W'(SUM_BYTES-1)) begin
                        idx_d = '0;
                        st_d  = ST_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            fl_q  <= '0;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            fl_q  <= fl_d;
            idx_q <= idx_d;
        end
    end
endmodule

// File: rtl/ckcrc_crc_unit.sv
module ckcrc_crc_unit
    import ckcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              step,
    input  logic              swap,
    input  logic              def_sel,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc_q
);
    logic [CRC_W-1:0] poly, upd, nxt;

    assign poly = def_sel ? POLY_CAST : POLY_STD;

    always_comb begin
        upd = step ? crc_step8(crc_q, data, poly) : crc_q;
        nxt = swap ? rev_in_bytes(upd) : upd;
        if (init) nxt = CRC_SEED;
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= CRC_SEED;
        else     crc_q <= nxt;
    end
endmodule

// File: rtl/ckcrc_sum_unit.sv
module ckcrc_sum_unit
    import ckcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [BYTE_W-1:0] data,
    output logic [SUM_W-1:0]  sum_q
);
    logic             odd_q;
    logic [SUM_W-1:0] word;

    assign word = odd_q ? {{BYTE_W{1'b0}}, data} : {data, {BYTE_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= SUM_SEED;
            odd_q <= 1'b0;
        end else if (clear) begin
            sum_q <= SUM_SEED;
            odd_q <= 1'b0;
        end else if (step) begin
            sum_q <= ones_add(sum_q, word);
            odd_q <= !odd_q;
        end
    end
endmodule

// File: rtl/inline_cksum_crc.sv
module inline_cksum_crc
    import ckcrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  flags,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        end_move,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic [15:0] csum_partial,
    output logic [31:0] crc_partial
);
    logic             crc_init, crc_step, crc_swap, crc_def;
    logic             sum_clear, sum_step, app_crc, app_sum;
    logic [IDX_W-1:0] app_idx;
    logic [BYTE_W-1:0] crc_byte, sum_byte, sum_in;
    logic [CRC_W-1:0]  crc_q;
    logic [SUM_W-1:0]  sum_q;

    ckcrc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .flags_in(move_flags_t'(flags)),
        .in_valid(in_valid), .end_move(end_move),
        .crc_init(crc_init), .crc_step(crc_step), .crc_swap(crc_swap), .crc_def(crc_def),
        .sum_clear(sum_clear), .sum_step(sum_step),
        .app_crc(app_crc), .app_sum(app_sum), .app_idx(app_idx)
    );

    ckcrc_crc_unit u_crc (
        .clk(clk), .rst(rst), .init(crc_init), .step(crc_step), .swap(crc_swap),
        .def_sel(crc_def), .data(in_data), .crc_q(crc_q)
    );

    assign crc_byte = ~crc_q[app_idx*BYTE_W +: BYTE_W];
    assign sum_byte = (app_idx == '0) ? ~sum_q[SUM_W-1 -: BYTE_W] : ~sum_q[BYTE_W-1:0];
    assign sum_in   = app_crc ? crc_byte : in_data;

    ckcrc_sum_unit u_sum (
        .clk(clk), .rst(rst), .clear(sum_clear), .step(sum_step),
        .data(sum_in), .sum_q(sum_q)
    );

    assign out_valid    = app_crc || app_sum;
    assign out_data     = app_crc ? crc_byte : (app_sum ? sum_byte : '0);
    assign csum_partial = sum_q;
    assign crc_partial  = crc_q;
endmodule

// File: rtl/ckcrc_checker.sv
module ckcrc_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [7:0]  flags,
    input logic        in_valid,
    input logic        end_move,
    input logic        out_valid,
    input logic [15:0] csum_partial,
    input logic [31:0] crc_partial
);
    assert_crc_seed_R2: assert property (@(posedge clk) disable iff (rst)
        (start && flags[4] && !out_valid) |=> (crc_partial == 32'hFFFFFFFF));

    assert_sum_seed_R2: assert property (@(posedge clk) disable iff (rst)
        (start && flags[1] && !out_valid) |=> (csum_partial == 16'h0000));

    assert_sum_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !in_valid && !start) |=> $stable(csum_partial));

    assert_crc_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> $stable(crc_partial));

    assert_append_after_end_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(end_move));
endmodule

bind inline_cksum_crc ckcrc_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .flags(flags), .in_valid(in_valid),
    .end_move(end_move), .out_valid(out_valid),
    .csum_partial(csum_partial), .crc_partial(crc_partial)
);

// File: tb/inline_cksum_crc_tb.sv
module inline_cksum_crc_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] flags = '0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic end_move = 1'b0;
    logic out_valid;
    logic [7:0] out_data;
    logic [15:0] csum_partial;
    logic [31:0] crc_partial;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    inline_cksum_crc u_dut (
        .clk(clk), .rst(rst), .start(start), .flags(flags), .in_valid(in_valid),
        .in_data(in_data), .end_move(end_move), .out_valid(out_valid),
        .out_data(out_data), .csum_partial(csum_partial), .crc_partial(crc_partial)
    );

    // flag bits
    localparam int F_SEN = 0, F_SRS = 1, F_SAP = 2, F_CEN = 3, F_CRS = 4, F_CAP = 5, F_SWP = 6, F_DEF = 7;

    // reference model state
    logic [31:0] m_crc = 32'hFFFFFFFF;
    int          m_sum = 0;
    bit          m_odd = 0;
    bit          m_open = 0;
    logic [7:0]  m_fl = '0;
    logic [7:0]  q_out[$];
    logic [7:0]  q_pend[$];

    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [7:0] b, bit cast);
        logic [31:0] p = cast ? 32'h82F63B78 : 32'hEDB88320;
        for (int i = 0; i < 8; i++) begin
            bit fb = c[0] ^ b[i];
            c = {1'b0, c[31:1]};
            if (fb) c = c ^ p;
        end
        return c;
    endfunction

    function automatic logic [7:0] flip(logic [7:0] b);
        return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
    endfunction

    task automatic ref_add(logic [7:0] b);
        int v = m_odd ? int'(b) : int'(b) * 256;
        m_sum = m_sum + v;
        if (m_sum > 65535) m_sum = m_sum - 65535;
        m_odd = !m_odd;
    endtask

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model(bit st, logic [7:0] fl, bit v, logic [7:0] d, bit e);
        bit busy = (q_out.size() > 0);
        if (st) begin
            if (!busy) begin
                m_fl = fl; m_open = 1;
                if (fl[F_CRS]) m_crc = 32'hFFFFFFFF;
                if (fl[F_SRS]) begin m_sum = 0; m_odd = 0; end
            end
        end else if (m_open) begin
            if (v) begin
                if (m_fl[F_CEN]) m_crc = ref_crc(m_crc, d, m_fl[F_DEF]);
                if (m_fl[F_SEN]) ref_add(d);
            end
            if (e) begin
                m_open = 0;
                if (m_fl[F_SWP]) m_crc = {flip(m_crc[31:24]), flip(m_crc[23:16]), flip(m_crc[15:8]), flip(m_crc[7:0])};
                if (m_fl[F_CAP]) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] cb = ~m_crc[k*8 +: 8];
                        q_pend.push_back(cb);
                        if (m_fl[F_SEN]) ref_add(cb);
                    end
                end
                if (m_fl[F_SAP]) begin
                    logic [15:0] s16 = 16'(m_sum);
                    q_pend.push_back(~s16[15:8]);
                    q_pend.push_back(~s16[7:0]);
                end
            end
        end
    endtask

    task automatic tick();
        bit had = (q_out.size() > 0);
        @(posedge clk);
        if (had) void'(q_out.pop_front());
        while (q_pend.size() > 0) q_out.push_back(q_pend.pop_front());
        #2;
        chk("R5 R6", "out_valid", 32'(out_valid), 32'(q_out.size() > 0));
        if (q_out.size() > 0) chk("R5 R6 R7", "out_data", 32'(out_data), 32'(q_out[0]));
        else begin
            chk("R3 R8", "crc_partial", crc_partial, m_crc);
            chk("R4 R7", "csum_partial", 32'(csum_partial), 32'(m_sum));
        end
    endtask

    task automatic cyc(bit st, logic [7:0] fl, bit v, logic [7:0] d, bit e);
        start = st; flags = fl; in_valid = v; in_data = d; end_move = e;
        model(st, fl, v, d, e);
        tick();
        start = 0; flags = '0; in_valid = 0; in_data = '0; end_move = 0;
    endtask

    task automatic send_digits(int from, int to);
        for (int i = from; i <= to; i++) cyc(0, 0, 1, 8'h30 + 8'(i), 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        chk("R1", "out_valid", 32'(out_valid), 0);
        chk("R1", "csum", 32'(csum_partial), 0);
        chk("R1", "crc", crc_partial, 32'hFFFFFFFF);

        // R3 standard polynomial, known vector
        cyc(1, 8'b0001_1011, 0, 0, 0);
        send_digits(1, 9);
        cyc(0, 0, 0, 0, 1);
        chk("R3", "std crc vector", crc_partial, 32'h340BC6D9);

        // R3 alternate polynomial
        cyc(1, 8'b1001_1011, 0, 0, 0);
        send_digits(1, 9);
        cyc(0, 0, 0, 0, 1);
        chk("R3", "alt crc vector", crc_partial, 32'h1CF96D7C);

        // R2 persistence across two moves, no reseed on the second
        cyc(1, 8'b0001_1011, 0, 0, 0);
        send_digits(1, 4);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 8'b0000_1001, 0, 0, 0);
        send_digits(5, 9);
        cyc(0, 0, 0, 0, 1);
        chk("R2", "crc across moves", crc_partial, 32'h340BC6D9);

        // R4 end-around carry
        cyc(1, 8'b0000_0011, 0, 0, 0);
        cyc(0, 0, 1, 8'hFF, 0); cyc(0, 0, 1, 8'hFF, 0);
        cyc(0, 0, 1, 8'h00, 0); cyc(0, 0, 1, 8'h01, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R4", "carry wrap", 32'(csum_partial), 32'h0001);

        // R5 R6 R7 R9: both appends, odd byte count, last byte with end
        cyc(1, 8'b0011_1111, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 8'hA5 ^ 8'(i * 37), 0);
        cyc(0, 0, 1, 8'h5C, 1);
        idle(8);

        // R8 bit reversal with append, alternate polynomial, sum continues (R4)
        cyc(1, 8'b1111_1101, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 0, 1, 8'(i * 61 + 3), 0);
        cyc(0, 0, 0, 0, 1);
        idle(8);

        // R10 ignored inputs: bytes and end while idle, start/bytes/end during append
        cyc(0, 0, 1, 8'h77, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(1, 8'b0011_1101, 0, 0, 0);
        cyc(0, 0, 1, 8'h12, 0);
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 1, 8'h99, 0);
        cyc(1, 8'b0001_0010, 0, 0, 0);
        cyc(0, 0, 1, 8'h44, 1);
        idle(8);

        // R3 R4 functions off: bytes leave both values unchanged
        cyc(1, 8'b0000_0000, 0, 0, 0);
        cyc(0, 0, 1, 8'hDE, 0); cyc(0, 0, 1, 8'hAD, 0);
        cyc(0, 0, 0, 0, 1);
        idle(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule